// File: doc/BRIEF.md
# Guarded Register Bank with Access Classification

This block is a small bank of memory-mapped control registers placed behind a legality checker. Each cycle a requester may present one register access, with its byte address, a write strobe and write data, and an access size. It also presents two flags. One says whether the requester runs in supervisor mode. The other says whether the same issue group carries a second register-space access alongside this one. The block classifies every access before letting it touch storage. It answers one cycle later with a response strobe, registered read data and a one-hot exception code.

Only the single most urgent fault is reported. A faulted access never changes a register and always returns zero data. A write aimed at a read-only register is accepted without complaint and simply has no effect. Registers that implement fewer than 32 bits keep their unused bits at zero whatever is written.

The register map, by byte offset, is as follows:
- 0x000: general control word, read/write, all 32 bits, resets to 0.
- 0x004: scratch word, read/write, all 32 bits, resets to 0.
- 0x008: identity constant 0x5A170001, read-only.
- 0x00C: limit field, read/write, bits 11:0 only, resets to 0x00000100.
- 0x010: configuration word, read/write, bits 23:16 and 7:0 only, resets to 0x00110022.
- 0x014: revision constant 0x00000003, read-only.

Every other word offset is unmapped.

Top module: `mmr_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register takes its reset value from the map, and `rsp_valid`, `rsp_exc` and `rsp_rdata` become zero.
- R2: Each request sampled with `req_valid` high produces exactly one response on the next cycle with `rsp_valid` high. A cycle without a request gives `rsp_valid` low with zero code and data. A legal read returns the register contents, and a legal write returns zero data.
- R3: An access with `req_super` low is refused with code 4'b0010 (protection).
- R4: An access is misaligned unless `req_size` is 2'b10 (word) and address bits 1:0 are zero. Sizes 2'b00 (byte), 2'b01 (half) and 2'b11 count as misaligned. A misaligned access gets code 4'b0100.
- R5: A word access whose word index (address bits 11:2) is 6 or more gets code 4'b1000 (nonexistent register).
- R6: An access with `req_dual` high gets code 4'b0001 and takes no effect.
- R7: When several faults apply, only one is reported, in this priority order: dual (4'b0001), then protection (4'b0010), then alignment (4'b0100), then nonexistent (4'b1000). `rsp_exc` is always one-hot or zero.
- R8: A legal write to a read-only register (0x008, 0x014) gives code 0 and leaves the register value unchanged.
- R9: Bits that a register does not implement read as zero, and writes to them are discarded: 0x00C keeps only bits 11:0, and 0x010 keeps only bits 23:16 and 7:0.
- R10: An access with a nonzero code changes no register and returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address inside the register window |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| req_wdata | input | 32 | Write data |
| req_super | input | 1 | Requester is in supervisor mode |
| req_dual | input | 1 | Issue group carries a second register-space access |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and faults |
| rsp_exc | output | 4 | One-hot exception code, zero when legal |

## Verification
The bench sends accesses that carry several faults at once, to show that only the top-priority code is reported. If the priority chain were reordered, a dual-flagged user access to a bad address would come back as a protection or address fault. After every faulted write, and after every write to a read-only register, the bench reads the target back. A design that leaked the write enable past the checker would show the new data there. Writes of all ones to the partially implemented registers expose any reserved bit that was stored. A reset applied while a request is in flight must clear both the pending response and the contents of the scratch register.

// File: rtl/mmr_guard_pkg.sv
// Package: shared types, exception codes and the register map of the guarded
// register bank. Assumes a 32-bit data path and word-indexed registers.
package mmr_guard_pkg;

    localparam int DATA_W = 32;
    localparam int N_REGS = 6;
    localparam int EXC_W  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef logic [EXC_W-1:0] exc_t;

    localparam exc_t EXC_NONE    = 4'b0000;
    localparam exc_t EXC_DUAL    = 4'b0001;
    localparam exc_t EXC_PRIV    = 4'b0010;
    localparam exc_t EXC_ALIGN   = 4'b0100;
    localparam exc_t EXC_ILLEGAL = 4'b1000;

    typedef struct packed {
        logic              ro;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] init;
    } reg_attr_t;

    // Per-index attributes: read-only flag, implemented-bit mask, reset value.
    function automatic reg_attr_t reg_attr(input int idx);
        reg_attr_t a;
        case (idx)
            0:       a = '{ro: 1'b0, mask: 32'hFFFF_FFFF, init: 32'h0000_0000};
            1:       a = '{ro: 1'b0, mask: 32'hFFFF_FFFF, init: 32'h0000_0000};
            2:       a = '{ro: 1'b1, mask: 32'hFFFF_FFFF, init: 32'h5A17_0001};
            3:       a = '{ro: 1'b0, mask: 32'h0000_0FFF, init: 32'h0000_0100};
            4:       a = '{ro: 1'b0, mask: 32'h00FF_00FF, init: 32'h0011_0022};
            5:       a = '{ro: 1'b1, mask: 32'hFFFF_FFFF, init: 32'h0000_0003};
            default: a = '{ro: 1'b1, mask: 32'h0000_0000, init: 32'h0000_0000};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/mmr_access_check.sv
// Access classifier: decides whether a register access may proceed and, if
// not, which single exception applies. Purely combinational. Assumes byte
// addressing with 4-byte registers packed from offset zero.
module mmr_access_check
    import mmr_guard_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NREGS  = N_REGS,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              super_mode,
    input  logic              dual,
    output exc_t              exc,
    output logic              grant,
    output logic [IDX_W-1:0]  idx
);

    logic aligned;
    logic mapped;

    // Derive alignment, decode and word index from the raw address.
    always_comb begin
        idx     = addr[ADDR_W-1:2];
        aligned = (size == SZ_WORD) && (addr[1:0] == 2'b00);
        mapped  = (idx < IDX_W'(NREGS));
    end

    // Fixed priority chain: dual, privilege, alignment, nonexistent.
    always_comb begin
        exc = EXC_NONE;
        if (valid) begin
            if (dual)             exc = EXC_DUAL;
            else if (!super_mode) exc = EXC_PRIV;
            else if (!aligned)    exc = EXC_ALIGN;
            else if (!mapped)     exc = EXC_ILLEGAL;
        end
        grant = valid && (exc == EXC_NONE);
    end

endmodule

// File: rtl/mmr_reg_file.sv
// Register storage: one entry per map index, each built from its attributes.
// Read-only entries are constants; writable entries store only implemented
// bits. Assumes the write enable arrives already qualified by the checker.
module mmr_reg_file
    import mmr_guard_pkg::*;
#(
    parameter int NREGS = N_REGS,
    parameter int IDX_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [NREGS*DATA_W-1:0] regs_flat
);

    logic [DATA_W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam reg_attr_t ATTR = reg_attr(g);
        if (ATTR.ro) begin : g_ro
            // Constant value; writes have nowhere to land.
            assign regs[g] = ATTR.init;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            // Load reset value, else store implemented bits of a granted write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= ATTR.init & ATTR.mask;
                else if (wr_en && (idx == IDX_W'(g)))
                    q <= wdata & ATTR.mask;
            end
            assign regs[g] = q;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    // Read multiplexer; unmatched index returns zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++)
            if (idx == IDX_W'(i)) rdata = regs[i];
    end

endmodule

// File: rtl/mmr_guard.sv
// Top: guarded register bank. Classifies each access, lets only legal ones
// reach storage, and registers a one-cycle-later response. Assumes at most
// one request per cycle on this port; a paired access is signalled by req_dual.
module mmr_guard
    import mmr_guard_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              req_super,
    input  logic              req_dual,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [3:0]        rsp_exc
);

    exc_t                     chk_exc;
    logic                     chk_grant;
    logic [IDX_W-1:0]         chk_idx;
    logic [DATA_W-1:0]        rf_rdata;
    logic [N_REGS*DATA_W-1:0] regs_flat;
    logic                     wr_en;

    mmr_access_check #(.ADDR_W(ADDR_W), .NREGS(N_REGS)) u_check (
        .valid      (req_valid),
        .addr       (req_addr),
        .size       (req_size),
        .super_mode (req_super),
        .dual       (req_dual),
        .exc        (chk_exc),
        .grant      (chk_grant),
        .idx        (chk_idx)
    );

    // Only a granted write may reach storage.
    assign wr_en = chk_grant && req_write;

    mmr_reg_file #(.NREGS(N_REGS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .idx       (chk_idx),
        .wdata     (req_wdata),
        .rdata     (rf_rdata),
        .regs_flat (regs_flat)
    );

    // Response register: strobe, code and data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_exc   <= EXC_NONE;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_exc   <= chk_exc;
            rsp_rdata <= (chk_grant && !req_write) ? rf_rdata : '0;
        end
    end

endmodule

// File: rtl/mmr_guard_chk.sv
// Checker: temporal properties of the guarded register bank, bound to the top.
module mmr_guard_chk
    import mmr_guard_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_write,
    input logic [ADDR_W-1:0]        req_addr,
    input logic [1:0]               req_size,
    input logic                     req_super,
    input logic                     req_dual,
    input logic                     rsp_valid,
    input logic [31:0]              rsp_rdata,
    input logic [3:0]               rsp_exc,
    input logic [N_REGS*DATA_W-1:0] regs_flat
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_exc == 4'b0 && rsp_rdata == 32'b0)); // R2
    AST_USER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dual && !req_super) |=> (rsp_exc == EXC_PRIV)); // R3
    AST_NARROW_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dual && req_super && req_size != SZ_WORD)
        |=> (rsp_exc == EXC_ALIGN)); // R4
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dual && req_super && req_size == SZ_WORD
         && req_addr[1:0] == 2'b00 && req_addr[ADDR_W-1:2] >= (ADDR_W-2)'(N_REGS))
        |=> (rsp_exc == EXC_ILLEGAL)); // R5
    AST_DUAL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dual) |=> (rsp_exc == EXC_DUAL)); // R6
    AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_exc)); // R7
    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc != 4'b0) |-> (rsp_rdata == 32'b0)); // R10
    AST_FAULT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != 4'b0) |-> $stable(regs_flat)); // R10

endmodule

bind mmr_guard mmr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_super (req_super),
    .req_dual  (req_dual),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_exc   (rsp_exc),
    .regs_flat (regs_flat)
);

// File: tb/mmr_guard_test.sv
`timescale 1ns/1ps
// Bench: vector table walked in order, then directed reset and idle checks.
module mmr_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        req_super = 1'b1;
    logic        req_dual = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  rsp_exc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    mmr_guard #(.ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_super(req_super), .req_dual(req_dual), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_exc(rsp_exc)
    );

    typedef struct packed {
        logic [3:0]  rid;
        logic        wr;
        logic        dual;
        logic        sup;
        logic [1:0]  sz;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [3:0]  exc;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b0, 1'b0, 1'b1, 2'b10, 12'h000, 32'h0,         4'b0000, 32'h0000_0000}, // R1 ctrl reset
        '{4'd2,  1'b1, 1'b0, 1'b1, 2'b10, 12'h000, 32'hDEAD_BEEF, 4'b0000, 32'h0000_0000}, // R2 write
        '{4'd2,  1'b0, 1'b0, 1'b1, 2'b10, 12'h000, 32'h0,         4'b0000, 32'hDEAD_BEEF}, // R2 read back
        '{4'd8,  1'b1, 1'b0, 1'b1, 2'b10, 12'h008, 32'h1234_5678, 4'b0000, 32'h0000_0000}, // R8 ro write
        '{4'd8,  1'b0, 1'b0, 1'b1, 2'b10, 12'h008, 32'h0,         4'b0000, 32'h5A17_0001}, // R8 unchanged
        '{4'd9,  1'b1, 1'b0, 1'b1, 2'b10, 12'h00C, 32'hFFFF_FFFF, 4'b0000, 32'h0000_0000}, // R9 limit
        '{4'd9,  1'b0, 1'b0, 1'b1, 2'b10, 12'h00C, 32'h0,         4'b0000, 32'h0000_0FFF}, // R9 masked
        '{4'd3,  1'b0, 1'b0, 1'b0, 2'b10, 12'h000, 32'h0,         4'b0010, 32'h0000_0000}, // R3 user read
        '{4'd3,  1'b1, 1'b0, 1'b0, 2'b10, 12'h004, 32'h1111_1111, 4'b0010, 32'h0000_0000}, // R3 user write
        '{4'd10, 1'b0, 1'b0, 1'b1, 2'b10, 12'h004, 32'h0,         4'b0000, 32'h0000_0000}, // R10 no effect
        '{4'd4,  1'b0, 1'b0, 1'b1, 2'b01, 12'h004, 32'h0,         4'b0100, 32'h0000_0000}, // R4 half size
        '{4'd4,  1'b0, 1'b0, 1'b1, 2'b10, 12'h006, 32'h0,         4'b0100, 32'h0000_0000}, // R4 offset 2
        '{4'd4,  1'b1, 1'b0, 1'b1, 2'b10, 12'h001, 32'h0BAD_0BAD, 4'b0100, 32'h0000_0000}, // R4 offset 1
        '{4'd10, 1'b0, 1'b0, 1'b1, 2'b10, 12'h000, 32'h0,         4'b0000, 32'hDEAD_BEEF}, // R10 no effect
        '{4'd5,  1'b0, 1'b0, 1'b1, 2'b10, 12'h018, 32'h0,         4'b1000, 32'h0000_0000}, // R5 first hole
        '{4'd5,  1'b1, 1'b0, 1'b1, 2'b10, 12'hFFC, 32'h5555_5555, 4'b1000, 32'h0000_0000}, // R5 top
        '{4'd6,  1'b1, 1'b1, 1'b1, 2'b10, 12'h000, 32'h0,         4'b0001, 32'h0000_0000}, // R6 dual write
        '{4'd6,  1'b0, 1'b0, 1'b1, 2'b10, 12'h000, 32'h0,         4'b0000, 32'hDEAD_BEEF}, // R6 no effect
        '{4'd7,  1'b0, 1'b1, 1'b0, 2'b00, 12'h019, 32'h0,         4'b0001, 32'h0000_0000}, // R7 all faults
        '{4'd7,  1'b0, 1'b0, 1'b0, 2'b01, 12'h019, 32'h0,         4'b0010, 32'h0000_0000}, // R7 priv wins
        '{4'd7,  1'b0, 1'b0, 1'b1, 2'b11, 12'h019, 32'h0,         4'b0100, 32'h0000_0000}, // R7 align wins
        '{4'd1,  1'b0, 1'b0, 1'b1, 2'b10, 12'h010, 32'h0,         4'b0000, 32'h0011_0022}, // R1 cfg reset
        '{4'd9,  1'b1, 1'b0, 1'b1, 2'b10, 12'h010, 32'hFFFF_FFFF, 4'b0000, 32'h0000_0000}, // R9 cfg write
        '{4'd9,  1'b0, 1'b0, 1'b1, 2'b10, 12'h010, 32'h0,         4'b0000, 32'h00FF_00FF}  // R9 masked
    };

    // Compare the visible response against the expectation.
    task automatic check(input int rid, input string what, input logic v,
                         input logic [3:0] e, input logic [31:0] d);
        n_tests++;
        if (rsp_valid !== v || rsp_exc !== e || rsp_rdata !== d) begin
            n_fail++;
            $display("FAIL R%0d %s: got valid=%0b exc=%b data=%h, expected valid=%0b exc=%b data=%h",
                     rid, what, rsp_valid, rsp_exc, rsp_rdata, v, e, d);
        end
    endtask

    // Present one access for one cycle; returns at the negedge after capture.
    task automatic access(input logic w, input logic du, input logic su,
                          input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_dual = du; req_super = su;
        req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_dual = 1'b0; req_super = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, "outputs in reset", 1'b0, 4'b0, 32'h0); // R1
        rst_n = 1'b1;
        @(negedge clk);
        check(2, "idle after reset", 1'b0, 4'b0, 32'h0); // R2

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].dual, VEC[i].sup, VEC[i].sz, VEC[i].addr, VEC[i].wdata);
            check(int'(VEC[i].rid), $sformatf("vector %0d", i), 1'b1, VEC[i].exc, VEC[i].rdata);
        end

        // R2: no request leaves the response strobe low.
        @(negedge clk);
        check(2, "idle cycle", 1'b0, 4'b0, 32'h0);

        // R1: reset arriving together with a request clears state and response.
        access(1'b1, 1'b0, 1'b1, 2'b10, 12'h004, 32'hCAFE_F00D);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 12'h000; req_size = 2'b10; rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b1;
        check(1, "reset drops pending response", 1'b0, 4'b0, 32'h0);
        access(1'b0, 1'b0, 1'b1, 2'b10, 12'h004, 32'h0);
        check(1, "scratch cleared by reset", 1'b1, 4'b0, 32'h0);
        access(1'b0, 1'b0, 1'b1, 2'b10, 12'h00C, 32'h0);
        check(1, "limit reset value", 1'b1, 4'b0, 32'h0000_0100);
        access(1'b0, 1'b0, 1'b1, 2'b10, 12'h014, 32'h0);
        check(8, "revision constant", 1'b1, 4'b0, 32'h0000_0003);
        access(1'b0, 1'b0, 1'b1, 2'b10, 12'h000, 32'h0);
        check(1, "ctrl cleared by reset", 1'b1, 4'b0, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule